// File: doc/BRIEF.md
# Interpolating Numerically Controlled Clock Source

This block is a numerically controlled clock source for a single system clock domain. A wide phase accumulator adds a tuning word on every clock. Its top bit is brought out unfiltered as a coarse square wave. The coarse wave carries one whole clock period of peak-to-peak edge jitter.

Each time that top bit changes, the block also emits an edge event. The event carries the polarity of the change and a fractional delay code, counted in delay taps measured from the preceding clock tick. The code places the true crossing inside the clock period. It is meant to steer a downstream fine delay element or a ramp converter, so that edge jitter falls well below one clock period.

The code comes from the residual phase left after the crossing, multiplied by the reciprocal of the step size. The reciprocal is read from a small table that is indexed by the normalised mantissa of the tuning word, so no divider is needed.

Tuning words enter over a valid/ready handshake. `tune_ready` is high while the one-entry holding register is empty. A word accepted when `tune_valid` and `tune_ready` are both high waits in that register, and `tune_ready` stays low until the word is taken into use. This is the only back-pressure. The edge event output has no ready: the events are bound to real time and cannot be stalled, so `edge_valid` is a one-cycle strobe.

Top module: `dds_edge_interp`

## Requirements
- R1: Each clock in which `clear` is low, the accumulator adds the active tuning word modulo 2^48. After the e-th such clock following a clear, `raw_msb` equals bit 47 of (e × word mod 2^48).
- R2: Every change of `raw_msb` caused by an add produces exactly one `edge_valid` strobe, two clocks after `raw_msb` changes. No strobe occurs otherwise.
- R3: `edge_rise` is 1 when the strobe reports a 0→1 change of the accumulator top bit and 0 when it reports a 1→0 change. It is valid in the same cycle as `edge_valid` and `edge_code`.
- R4: `edge_code` is the number of 1/128-period taps from the tick before the crossing add to the crossing. With the crossing add numbered n, the value (n−1)×128 + `edge_code` is within 3 taps of 128 × L × 2^47 / word, where L is the crossing's ordinal since the clear.
- R5: `edge_code` always lies in 0..127. A word that divides the accumulator range into a whole number of clocks (for example 2^46, or 2^45) gives code 127 on every edge.
- R6: An accepted word is normally taken into use on the clock whose add makes the top bit rise. The add that makes the top bit rise and the residual it produces still use the previous word. While a word is waiting, `tune_ready` is low.
- R7: With an active word of zero the output is static and no strobes occur. A word offered in that state is taken into use on the clock after it is accepted.
- R8: A word of 2^47 or more is clamped to 2^47−1 at acceptance, so that each add produces at most one crossing.
- R9: While `clear` is high, the accumulator is held at zero, strobes already in flight are cancelled, and a waiting word is taken into use at once.
- R10: After reset, `raw_msb`, `edge_valid`, `edge_rise` and `edge_code` are 0 and `tune_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of accumulator and edge pipeline |
| tune_valid | input | 1 | Tuning word offered |
| tune_ready | output | 1 | Holding register empty; word will be accepted |
| tune_word | input | 48 | Phase step per clock |
| raw_msb | output | 1 | Accumulator top bit, uninterpolated |
| edge_valid | output | 1 | One-cycle edge event strobe |
| edge_rise | output | 1 | Edge polarity, 1 = rising |
| edge_code | output | 7 | Fine delay in taps after the preceding tick |

## Verification
Two things can land on the same clock: the commit of a waiting tuning word and the rising crossing whose residual must still be scaled by the old step. The bench provokes this by offering a slower word in the middle of a period of a quarter-rate clock. It then checks three things. `tune_ready` must stay low until the add that makes the top bit rise. The rising edge from that add must still show the old spacing. The next falling edge must show the new spacing, four adds later, rather than a blend of the two steps. The same run also checks that no strobe appears in the idle cycles between these edges.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;

  localparam int DEF_ACC_W      = 48;
  localparam int DEF_TAP_BITS   = 7;
  localparam int DEF_MANT_BITS  = 6;
  localparam int DEF_RES_BITS   = 16;
  localparam int DEF_RECIP_BITS = 16;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tune_valid,
  output logic             tune_ready,
  input  logic [ACC_W-1:0] tune_word,
  output logic             acc_msb,
  output logic             tgl_q,
  output logic             tgl_rise_q,
  output logic [ACC_W-2:0] resid_q,
  output logic [ACC_W-2:0] step_q
);
  localparam logic [ACC_W-2:0] STEP_MAX = {(ACC_W-1){1'b1}};

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-2:0] active_q;
  logic [ACC_W-2:0] pend_q;
  logic [ACC_W-2:0] word_lim;
  logic             pend_full_q;
  logic             toggle;
  logic             rise_now;
  logic             accept;
  logic             commit;

  // words at or above half scale could cross twice per add: clamp them
  assign word_lim = tune_word[ACC_W-1] ? STEP_MAX : tune_word[ACC_W-2:0];
  assign sum      = acc_q + {1'b0, active_q};
  assign toggle   = sum[ACC_W-1] ^ acc_q[ACC_W-1];
  assign rise_now = toggle & sum[ACC_W-1];
  assign accept   = tune_valid & ~pend_full_q;
  assign commit   = pend_full_q & (clear | (active_q == '0) | rise_now);

  assign tune_ready = ~pend_full_q;
  assign acc_msb    = acc_q[ACC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= '0;
      pend_q      <= '0;
      pend_full_q <= 1'b0;
    end else begin
      if (accept) pend_q <= word_lim;
      if (commit) active_q <= pend_q;
      if (commit)      pend_full_q <= 1'b0;
      else if (accept) pend_full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      tgl_q      <= 1'b0;
      tgl_rise_q <= 1'b0;
      resid_q    <= '0;
      step_q     <= '0;
    end else if (clear) begin
      acc_q      <= '0;
      tgl_q      <= 1'b0;
      tgl_rise_q <= 1'b0;
    end else begin
      acc_q      <= sum;
      tgl_q      <= toggle;
      tgl_rise_q <= sum[ACC_W-1];
      resid_q    <= sum[ACC_W-2:0];
      step_q     <= active_q;
    end
  end
endmodule

// File: rtl/dds_recip_norm.sv
module dds_recip_norm #(
  parameter int ACC_W      = 48,
  parameter int MANT_BITS  = 6,
  parameter int RES_BITS   = 16,
  parameter int RECIP_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  in_valid,
  input  logic                  in_rise,
  input  logic [ACC_W-2:0]      resid,
  input  logic [ACC_W-2:0]      step,
  output logic                  s1_valid,
  output dds_pkg::edge_pol_e    s1_pol,
  output logic [RES_BITS-1:0]   s1_rt,
  output logic [RECIP_BITS-1:0] s1_recip
);
  localparam int LUT_N = 1 << MANT_BITS;
  localparam int POS_W = $clog2(ACC_W - 1);

  logic [RECIP_BITS-1:0] lut [LUT_N];
  logic [POS_W-1:0]      lead;
  logic [POS_W-1:0]      shamt;
  logic [ACC_W-2:0]      step_n;
  logic [ACC_W-2:0]      resid_n;
  logic [MANT_BITS-1:0]  mant;
  logic [RES_BITS-1:0]   rt;

  // reciprocal of each mantissa bin, taken at the bin midpoint
  for (genvar gi = 0; gi < LUT_N; gi++) begin : g_lut
    localparam longint NUM = longint'(1) << (MANT_BITS + RECIP_BITS + 1);
    localparam longint DEN = (longint'(2) << MANT_BITS) + 2 * gi + 1;
    assign lut[gi] = RECIP_BITS'((NUM + DEN / 2) / DEN);
  end

  always_comb begin
    lead = '0;
    for (int i = 0; i < ACC_W - 1; i++) begin
      if (step[i]) lead = POS_W'(i);
    end
  end

  assign shamt   = POS_W'(ACC_W - 2) - lead;
  assign step_n  = step << shamt;
  assign resid_n = resid << shamt;
  assign mant    = MANT_BITS'(step_n >> (ACC_W - 2 - MANT_BITS));
  assign rt      = RES_BITS'(resid_n >> (ACC_W - 1 - RES_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_pol   <= dds_pkg::EDGE_FALL;
      s1_rt    <= '0;
      s1_recip <= '0;
    end else if (clear) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_pol   <= in_rise ? dds_pkg::EDGE_RISE : dds_pkg::EDGE_FALL;
      s1_rt    <= rt;
      s1_recip <= lut[mant];
    end
  end
endmodule

// File: rtl/dds_delay_scale.sv
module dds_delay_scale #(
  parameter int TAP_BITS   = 7,
  parameter int RES_BITS   = 16,
  parameter int RECIP_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  in_valid,
  input  dds_pkg::edge_pol_e    in_pol,
  input  logic [RES_BITS-1:0]   rt,
  input  logic [RECIP_BITS-1:0] recip,
  output logic                  edge_valid,
  output logic                  edge_rise,
  output logic [TAP_BITS-1:0]   edge_code
);
  localparam int PW     = RES_BITS + RECIP_BITS;
  localparam int SHIFT  = RES_BITS - 1 + RECIP_BITS - TAP_BITS;
  localparam int FRAC_W = PW + 1 - SHIFT;
  localparam int TAPS   = 1 << TAP_BITS;
  localparam logic [PW:0] BIAS = (PW + 1)'(1) << (SHIFT - 1);

  logic [PW-1:0]       prod;
  logic [PW:0]         prod_r;
  logic [FRAC_W-1:0]   frac;
  logic [TAP_BITS-1:0] code_n;

  assign prod   = PW'(rt) * PW'(recip);
  assign prod_r = {1'b0, prod} + BIAS;
  assign frac   = FRAC_W'(prod_r >> SHIFT);

  // code = taps minus the fraction of a period already elapsed, saturated
  always_comb begin
    if (frac == '0)                     code_n = TAP_BITS'(TAPS - 1);
    else if (frac >= FRAC_W'(TAPS))     code_n = '0;
    else                                code_n = TAP_BITS'(FRAC_W'(TAPS) - frac);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_valid <= 1'b0;
      edge_rise  <= 1'b0;
      edge_code  <= '0;
    end else if (clear) begin
      edge_valid <= 1'b0;
    end else begin
      edge_valid <= in_valid;
      if (in_valid) begin
        edge_rise <= (in_pol == dds_pkg::EDGE_RISE);
        edge_code <= code_n;
      end
    end
  end
endmodule

// File: rtl/dds_edge_interp.sv
module dds_edge_interp #(
  parameter int ACC_W      = dds_pkg::DEF_ACC_W,
  parameter int TAP_BITS   = dds_pkg::DEF_TAP_BITS,
  parameter int MANT_BITS  = dds_pkg::DEF_MANT_BITS,
  parameter int RES_BITS   = dds_pkg::DEF_RES_BITS,
  parameter int RECIP_BITS = dds_pkg::DEF_RECIP_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                tune_valid,
  output logic                tune_ready,
  input  logic [ACC_W-1:0]    tune_word,
  output logic                raw_msb,
  output logic                edge_valid,
  output logic                edge_rise,
  output logic [TAP_BITS-1:0] edge_code
);
  logic                  tgl;
  logic                  tgl_rise;
  logic [ACC_W-2:0]      resid;
  logic [ACC_W-2:0]      step;
  logic                  s1_valid;
  dds_pkg::edge_pol_e    s1_pol;
  logic [RES_BITS-1:0]   s1_rt;
  logic [RECIP_BITS-1:0] s1_recip;

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .tune_valid(tune_valid), .tune_ready(tune_ready), .tune_word(tune_word),
    .acc_msb(raw_msb), .tgl_q(tgl), .tgl_rise_q(tgl_rise),
    .resid_q(resid), .step_q(step)
  );

  dds_recip_norm #(
    .ACC_W(ACC_W), .MANT_BITS(MANT_BITS),
    .RES_BITS(RES_BITS), .RECIP_BITS(RECIP_BITS)
  ) u_norm (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .in_valid(tgl), .in_rise(tgl_rise), .resid(resid), .step(step),
    .s1_valid(s1_valid), .s1_pol(s1_pol), .s1_rt(s1_rt), .s1_recip(s1_recip)
  );

  dds_delay_scale #(
    .TAP_BITS(TAP_BITS), .RES_BITS(RES_BITS), .RECIP_BITS(RECIP_BITS)
  ) u_scale (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .in_valid(s1_valid), .in_pol(s1_pol), .rt(s1_rt), .recip(s1_recip),
    .edge_valid(edge_valid), .edge_rise(edge_rise), .edge_code(edge_code)
  );
endmodule

// File: rtl/dds_edge_interp_chk.sv
module dds_edge_interp_chk (
  input logic clk,
  input logic rst_n,
  input logic clear,
  input logic tune_valid,
  input logic tune_ready,
  input logic raw_msb,
  input logic edge_valid,
  input logic edge_rise
);
  // R2: a strobe always reports a top-bit change two clocks earlier
  p_strobe_after_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_valid |-> ($past(raw_msb, 2) != $past(raw_msb, 3)));

  // R3: polarity matches the new top-bit level
  p_polarity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_valid |-> (edge_rise == $past(raw_msb, 2)));

  // R6: an accepted word blocks the holding register
  p_hold_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tune_valid && tune_ready) |=> !tune_ready);

  // R6: ready only drops through a handshake
  p_ready_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tune_ready && !tune_valid) |=> tune_ready);

  // R9: clear cancels every strobe in flight
  p_clear_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_valid |-> (!$past(clear, 1) && !$past(clear, 2) && !$past(clear, 3)));
endmodule

bind dds_edge_interp dds_edge_interp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear),
  .tune_valid(tune_valid), .tune_ready(tune_ready),
  .raw_msb(raw_msb), .edge_valid(edge_valid), .edge_rise(edge_rise)
);

// File: tb/dds_edge_interp_test.sv
module dds_edge_interp_test;
  localparam int AW   = 48;
  localparam int TB   = 7;
  localparam int TAPS = 128;
  localparam int RUN  = 48;
  localparam int NV   = 7;

  // stimulus: tuning word, exact-divisor flag, expected strobe count in RUN clocks
  localparam logic [AW-1:0] V_WORD [NV] = '{
    48'h4000_0000_0000, 48'h2000_0000_0000, 48'h3333_3333_3333,
    48'h1555_5555_5555, 48'h0A3D_70A3_D70A, 48'hC000_0000_0000,
    48'h7FFF_FFFF_FFFF};
  localparam bit V_EXACT [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam int V_CNT   [NV] = '{23, 11, 18, 7, 3, 45, 45};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic          tune_valid = 1'b0;
  logic [AW-1:0] tune_word = '0;
  logic          tune_ready;
  logic          raw_msb;
  logic          edge_valid;
  logic          edge_rise;
  logic [TB-1:0] edge_code;

  dds_edge_interp uut (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .tune_valid(tune_valid), .tune_ready(tune_ready), .tune_word(tune_word),
    .raw_msb(raw_msb), .edge_valid(edge_valid), .edge_rise(edge_rise),
    .edge_code(edge_code)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] clampw(input logic [AW-1:0] w);
    return w[AW-1] ? {1'b0, {(AW-1){1'b1}}} : w;
  endfunction

  task automatic load_in_clear(input logic [AW-1:0] w);
    @(negedge clk); clear = 1'b1; tune_word = w; tune_valid = 1'b1;
    @(negedge clk); tune_valid = 1'b0;
    @(negedge clk);
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic run_vec(input int i);
    logic [AW-1:0] wc;
    longint cnt, msb_bad, ideal, rec, diff, prod;
    wc = clampw(V_WORD[i]);
    load_in_clear(V_WORD[i]);
    cnt = 0; msb_bad = 0;
    for (int e = 1; e <= RUN; e++) begin
      @(negedge clk);
      prod = longint'(e) * longint'(wc);
      if (raw_msb !== prod[AW-1]) msb_bad++;
      if (edge_valid) begin
        cnt++;
        chk(edge_rise == cnt[0], "R3", longint'(edge_rise), cnt % 2);
        ideal = (cnt <<< (AW - 1 + TB)) / longint'(wc);
        rec   = longint'(e - 3) * TAPS + longint'(edge_code);
        diff  = (rec > ideal) ? rec - ideal : ideal - rec;
        chk(diff <= 3, "R4", rec, ideal);
        if (V_EXACT[i]) chk(edge_code == TB'(TAPS - 1), "R5", longint'(edge_code), TAPS - 1);
      end
    end
    chk(msb_bad == 0, "R1", msb_bad, 0);
    chk(cnt == V_CNT[i], (V_WORD[i] != wc) ? "R8" : "R2", cnt, V_CNT[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int strobes;
    int raw_hi;
    bit [13:0] seen;
    bit [13:0] want;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk(edge_valid == 1'b0, "R10", longint'(edge_valid), 0);
    chk(raw_msb == 1'b0, "R10", longint'(raw_msb), 0);
    chk(tune_ready == 1'b1, "R10", longint'(tune_ready), 1);
    chk(edge_code == '0, "R10", longint'(edge_code), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R6: word change in mid-period of a quarter-rate clock
    load_in_clear(48'h4000_0000_0000);
    seen = '0;
    for (int e = 1; e <= 13; e++) begin
      @(negedge clk);
      if (edge_valid) begin
        seen[e] = 1'b1;
        chk(edge_code == TB'(TAPS - 1), "R5", longint'(edge_code), TAPS - 1);
      end
      if (e == 2) begin tune_word = 48'h2000_0000_0000; tune_valid = 1'b1; end
      if (e == 3) tune_valid = 1'b0;
      if (e >= 3 && e <= 5) chk(tune_ready == 1'b0, "R6", longint'(tune_ready), 0);
      if (e == 6) chk(tune_ready == 1'b1, "R6", longint'(tune_ready), 1);
    end
    want = '0; want[4] = 1'b1; want[6] = 1'b1; want[8] = 1'b1; want[12] = 1'b1;
    chk(seen == want, "R6", longint'(seen), longint'(want));

    // R9: clear kills the strobe in flight and zeroes the accumulator
    load_in_clear(48'h4000_0000_0000);
    strobes = 0;
    @(negedge clk); @(negedge clk);
    chk(raw_msb == 1'b1, "R1", longint'(raw_msb), 1);
    clear = 1'b1;
    for (int e = 0; e < 4; e++) begin
      @(negedge clk);
      if (edge_valid) strobes++;
      if (e == 0) chk(raw_msb == 1'b0, "R9", longint'(raw_msb), 0);
    end
    chk(strobes == 0, "R9", strobes, 0);
    clear = 1'b0;

    // R7: zero word is static, then a new word applies immediately
    load_in_clear('0);
    strobes = 0; raw_hi = 0;
    for (int e = 0; e < 20; e++) begin
      @(negedge clk);
      if (edge_valid) strobes++;
      if (raw_msb) raw_hi++;
    end
    chk(strobes == 0, "R7", strobes, 0);
    chk(raw_hi == 0, "R7", raw_hi, 0);
    tune_word = 48'h4000_0000_0000; tune_valid = 1'b1;
    @(negedge clk); tune_valid = 1'b0;
    @(negedge clk); chk(raw_msb == 1'b0, "R7", longint'(raw_msb), 0);
    @(negedge clk); chk(raw_msb == 1'b0, "R7", longint'(raw_msb), 0);
    @(negedge clk); chk(raw_msb == 1'b1, "R7", longint'(raw_msb), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule